// File: doc/BRIEF.md
# Signed-Magnitude Adder-Subtractor

This block adds or subtracts two operands given in sign-and-magnitude form. Every operand and the result are N bits wide: bit N-1 is the sign (1 means negative) and bits N-2:0 hold the unsigned magnitude. A single control bit chooses between A+B and A-B. The unit is purely combinational. Its output is a sign-and-magnitude result plus an overflow flag.

The unit does not run add or subtract directly. It first takes the parity of the two operand signs and the control bit. Even parity means the magnitudes are summed. Odd parity means the second magnitude is taken from the first. That subtraction uses one unsigned adder fed with the inverted subtrahend and a carry-in of 1. A missing end carry shows that a borrow happened. The raw sum is then negated to two's complement and the sign of the first operand is flipped. A zero magnitude is always shown with a positive sign.

Top module: `sm_addsub`

## Requirements
- R1: Operand and result format: bit N-1 is the sign (1 = negative) and bits N-2:0 are the magnitude. The effective operation is sign(A) XOR sign(B) XOR sub_i, where sub_i = 1 requests A-B. The value 0 selects a magnitude sum and 1 selects a magnitude difference.
- R2: When the effective operation is a sum, the result magnitude equals the low N-1 bits of magA + magB.
- R3: When the effective operation is a sum, ovf_o is 1 exactly when magA + magB does not fit in N-1 bits.
- R4: When the effective operation is a sum and the result magnitude is non-zero, the result sign equals sign(A).
- R5: When the effective operation is a difference and magA >= magB, the result magnitude is magA - magB. If that magnitude is non-zero, the sign equals sign(A).
- R6: When the effective operation is a difference and magA < magB (a borrow), the result magnitude is magB - magA and the sign is the inverse of sign(A).
- R7: When the effective operation is a difference, ovf_o is 0.
- R8: Whenever the result magnitude is zero, the result sign bit is 0. This holds in the overflow case too.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand, sign in bit N-1, magnitude below |
| b_i | input | N | Second operand, same format |
| sub_i | input | 1 | 1 requests A-B, 0 requests A+B |
| res_o | output | N | Result in sign-and-magnitude form |
| ovf_o | output | 1 | Magnitude sum did not fit in N-1 bits |

## Verification
The assertions assume that the inputs are two-valued and stable once combinational settling is over. They also assume that each input combination is a legal encoding, so the bit pattern for negative zero is accepted on an input like any other operand. The stimulus drives only fully known values, always on the falling clock edge, and samples a nanosecond later. Every bit pattern is therefore reachable, including negative-zero inputs, maximum magnitudes and equal magnitudes. The directed cases go first and pin down the carry boundary and the borrow boundary. The random loop then covers the mix of signs and control values.

// File: rtl/sm_pkg.sv
package sm_pkg;
   typedef enum logic [0:0] {
      ADD_RIPPLE = 1'b0,
      ADD_BEHAV  = 1'b1
   } add_style_e;

   typedef enum logic [0:0] {
      NEG_INV_INC = 1'b0,
      NEG_SCAN    = 1'b1
   } neg_style_e;

   function automatic logic sign_parity(input logic sa, input logic sb, input logic sub);
      return sa ^ sb ^ sub;
   endfunction
endpackage

// File: rtl/sm_mag_adder.sv
module sm_mag_adder
   import sm_pkg::*;
#(
   parameter int         W     = 7,
   parameter add_style_e STYLE = ADD_RIPPLE
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o
);
   if (W < 1) begin : g_bad_width
      $error("sm_mag_adder: W must be at least 1");
   end

   if (STYLE == ADD_RIPPLE) begin : g_ripple
      logic [W:0] carry;
      assign carry[0] = cin_i;
      for (genvar i = 0; i < W; i++) begin : g_cell
         logic p, g;
         assign p          = x_i[i] ^ y_i[i];
         assign g          = x_i[i] & y_i[i];
         assign sum_o[i]   = p ^ carry[i];
         assign carry[i+1] = g | (p & carry[i]);
      end
      assign cout_o = carry[W];
   end else begin : g_behav
      logic [W:0] wide;
      assign wide   = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
      assign sum_o  = wide[W-1:0];
      assign cout_o = wide[W];
   end
endmodule

// File: rtl/sm_negate.sv
module sm_negate
   import sm_pkg::*;
#(
   parameter int         W     = 7,
   parameter neg_style_e STYLE = NEG_INV_INC
) (
   input  logic [W-1:0] v_i,
   output logic [W-1:0] neg_o
);
   if (STYLE == NEG_INV_INC) begin : g_inv_inc
      logic [W:0] inc;
      assign inc[0] = 1'b1;
      for (genvar i = 0; i < W; i++) begin : g_bit
         logic inv;
         assign inv      = ~v_i[i];
         assign neg_o[i] = inv ^ inc[i];
         assign inc[i+1] = inv & inc[i];
      end
   end else begin : g_scan
      logic [W:0] seen;
      assign seen[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign neg_o[i]  = v_i[i] ^ seen[i];
         assign seen[i+1] = seen[i] | v_i[i];
      end
   end
endmodule

// File: rtl/sm_control.sv
module sm_control
   import sm_pkg::*;
(
   input  logic sa_i,
   input  logic sb_i,
   input  logic sub_i,
   input  logic cout_i,
   output logic diff_o,
   output logic borrow_o,
   output logic ovf_o,
   output logic sign_raw_o
);
   assign diff_o     = sign_parity(sa_i, sb_i, sub_i);
   assign borrow_o   = diff_o & ~cout_i;
   assign ovf_o      = ~diff_o & cout_i;
   assign sign_raw_o = sa_i ^ borrow_o;
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub
   import sm_pkg::*;
#(
   parameter int         N         = 8,
   parameter add_style_e ADD_STYLE = ADD_RIPPLE,
   parameter neg_style_e NEG_STYLE = NEG_INV_INC
) (
   input  logic [N-1:0] a_i,
   input  logic [N-1:0] b_i,
   input  logic         sub_i,
   output logic [N-1:0] res_o,
   output logic         ovf_o
);
   localparam int M = N - 1;

   if (N < 2) begin : g_bad_n
      $error("sm_addsub: N must be at least 2");
   end

   logic         sa, sb;
   logic [M-1:0] ma, mb, mb_eff, raw_sum, raw_neg, mag;
   logic         cout, diff, borrow, ovf, sign_raw;

   assign sa = a_i[N-1];
   assign sb = b_i[N-1];
   assign ma = a_i[M-1:0];
   assign mb = b_i[M-1:0];

   sm_control u_ctrl (
      .sa_i      (sa),
      .sb_i      (sb),
      .sub_i     (sub_i),
      .cout_i    (cout),
      .diff_o    (diff),
      .borrow_o  (borrow),
      .ovf_o     (ovf),
      .sign_raw_o(sign_raw)
   );

   assign mb_eff = diff ? ~mb : mb;

   sm_mag_adder #(.W(M), .STYLE(ADD_STYLE)) u_add (
      .x_i   (ma),
      .y_i   (mb_eff),
      .cin_i (diff),
      .sum_o (raw_sum),
      .cout_o(cout)
   );

   sm_negate #(.W(M), .STYLE(NEG_STYLE)) u_neg (
      .v_i  (raw_sum),
      .neg_o(raw_neg)
   );

   assign mag   = borrow ? raw_neg : raw_sum;
   assign res_o = {sign_raw & (|mag), mag};
   assign ovf_o = ovf;

   always_comb begin
      if (diff) begin
         assert_sub_no_ovf_R7: assert (!ovf_o)
            else $error("overflow flagged on a magnitude difference");
         assert_sub_bound_R5: assert (res_o[M-1:0] <= ((ma > mb) ? ma : mb))
            else $error("difference magnitude exceeds both operands");
      end
      if (res_o[M-1:0] == '0) begin
         assert_no_neg_zero_R8: assert (!res_o[N-1])
            else $error("negative zero produced");
      end
      if (!diff && res_o[M-1:0] != '0) begin
         assert_add_sign_R4: assert (res_o[N-1] == a_i[N-1])
            else $error("sum sign differs from first operand");
      end
      if (!diff && !ovf_o) begin
         assert_no_overflow_R3: assert (res_o[M-1:0] >= ma && res_o[M-1:0] >= mb)
            else $error("sum without overflow smaller than an operand");
      end
   end
endmodule

// File: tb/tb_sm_addsub.sv
`timescale 1ns/1ps
module tb_sm_addsub;
   localparam int N = 8;
   localparam int M = N - 1;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [N-1:0] a, b;
   logic         sub;
   logic [N-1:0] res;
   logic         ovf;
   int           checks = 0;
   int           errors = 0;
   bit           done   = 0;

   always #2 clk = ~clk;

   sm_addsub #(.N(N)) dut (
      .a_i(a), .b_i(b), .sub_i(sub), .res_o(res), .ovf_o(ovf)
   );

   function automatic logic [N:0] model(input logic [N-1:0] x, input logic [N-1:0] y, input logic s);
      int ma, mb, m;
      logic sg, ov, d;
      ma = int'(x[M-1:0]);
      mb = int'(y[M-1:0]);
      d  = x[N-1] ^ y[N-1] ^ s;
      ov = 1'b0;
      if (!d) begin
         m  = ma + mb;
         ov = (m >= (1 << M));
         m  = m % (1 << M);
         sg = x[N-1];
      end else if (ma >= mb) begin
         m  = ma - mb;
         sg = x[N-1];
      end else begin
         m  = mb - ma;
         sg = ~x[N-1];
      end
      if (m == 0) sg = 1'b0;
      return {ov, sg, m[M-1:0]};
   endfunction

   task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y, input logic s, input string tag);
      logic [N:0] exp;
      @(negedge clk);
      a = x; b = y; sub = s;
      #1;
      exp = model(x, y, s);
      checks++;
      if ({ovf, res} !== exp) begin
         errors++;
         $display("FAIL %s a=%h b=%h sub=%b actual ovf=%b res=%h expected ovf=%b res=%h",
                  tag, x, y, s, ovf, res, exp[N], exp[N-1:0]);
      end
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 32'h5eed;
      void'($urandom(seed));
      a = '0; b = '0; sub = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      apply(8'h00, 8'h00, 1'b0, "R2 zero inputs");
      apply(8'h03, 8'h04, 1'b0, "R2 3+4");
      apply(8'h83, 8'h84, 1'b0, "R4 -3 + -4");
      apply(8'd100, 8'd50, 1'b0, "R3 overflow 100+50");
      apply(8'h7F, 8'h01, 1'b0, "R8 overflow to zero");
      apply(8'hFF, 8'h81, 1'b0, "R8 negative overflow to zero");
      apply(8'h7F, 8'h00, 1'b0, "R3 max no overflow");
      apply(8'h05, 8'h03, 1'b1, "R5 5-3");
      apply(8'h03, 8'h05, 1'b1, "R6 3-5 borrow");
      apply(8'h85, 8'h85, 1'b1, "R8 -5 - -5");
      apply(8'h83, 8'h05, 1'b0, "R6 -3 + 5");
      apply(8'h05, 8'h83, 1'b0, "R1 5 + -3 difference");
      apply(8'h05, 8'h83, 1'b1, "R1 5 - -3 sum");
      apply(8'h7F, 8'hFF, 1'b0, "R7 max difference no overflow");
      apply(8'h00, 8'h7F, 1'b1, "R6 0-127");
      apply(8'h80, 8'h00, 1'b0, "R8 negative zero input");
      for (int i = 0; i < 3000; i++) begin
         apply(N'($urandom), N'($urandom), 1'($urandom), "R1 R2 R3 R5 R6 R7 random");
      end
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule